// File: doc/BRIEF.md
# Priority Interrupt Level Resolver

This block sits between a processor's interrupt sources and its trap logic. Every clock cycle it merges sixteen external level-sensitive request lines with a software interrupt register to form one pending-level vector. It finds the highest pending level and turns it into an external-interrupt trap index. It then decides whether that index may replace the trap index the core holds at the moment.

The core feeds its current trap index back in on `cur_idx` and takes the resolved index from `idx_q`. The block gives a one-cycle strobe each time it installs a different index. It holds a hard-interrupt request level until nothing is pending any more. It also raises a wake signal when a sleeping core sees a new external request.

Top module: `pil_resolver`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `idx_q`, `req_pulse`, `req_level` and `wake` are all 0.
- R2: The pending vector is the OR of three sources: `ext_irq`, `soft_int` with bit 0 cleared, and `soft_int` bit 0 (the timer bit) moved to level 14. `soft_int` bit 0 alone therefore resolves to level 14, never to level 0.
- R3: The highest set level among 15 down to 1 is selected. Level 0 is never selected, so a vector holding only bit 0 leaves `idx_q` equal to `cur_idx`.
- R4: An installed index equals 0x40 OR the 4-bit level number (trap types 0x41 to 0x4F). It appears on `idx_q` one clock after the inputs that caused it.
- R5: A level is installed only when `cur_idx` is 0 or `cur_idx[8:4]` equals 4 (the external-interrupt class). Any other `cur_idx` is passed to `idx_q` unchanged, with no strobe.
- R6: `req_pulse` is high for one cycle exactly when the installed index differs from `cur_idx`.
- R7: When the pending vector is all zero and `cur_idx` is in the external-interrupt class, `idx_q` becomes 0 and `req_level` goes low on the next clock.
- R8: `req_level` goes high together with `req_pulse` and otherwise keeps its value until a withdrawal under R7.
- R9: `wake` is high one clock after a cycle in which `halted` is high and at least one `ext_irq` line went from 0 to 1. Lowering a line never raises `wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq | input | 16 | External interrupt level lines, one per level |
| soft_int | input | 16 | Software interrupt register; bit 0 is the timer bit |
| cur_idx | input | 9 | Trap index currently pending in the core |
| halted | input | 1 | Core is halted |
| idx_q | output | 9 | Resolved trap index |
| req_pulse | output | 1 | One-cycle strobe when a new index is installed |
| req_level | output | 1 | Held hard-interrupt request |
| wake | output | 1 | Wake the halted core |

## Verification
The assertions assume that `cur_idx` is a stable value for the whole clock cycle. They do not assume it equals the last `idx_q`: the core may load a non-external trap at any time. The bench normally feeds `idx_q` back into `cur_idx` and sometimes overrides it with zero or with a non-external trap index, so that both the feedback path and the blocking path are exercised. Random `ext_irq` patterns are kept sparse and are all-zero in some steps, so that the withdrawal path and the rising-edge wake path both occur often.

// File: rtl/pil_resolver.sv
module pil_resolver #(
  parameter int LEVELS      = 16,
  parameter int IDX_W       = 9,
  parameter int EXT_BASE    = 'h40,
  parameter int TIMER_LEVEL = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] ext_irq,
  input  logic [LEVELS-1:0] soft_int,
  input  logic [IDX_W-1:0]  cur_idx,
  input  logic              halted,
  output logic [IDX_W-1:0]  idx_q,
  output logic              req_pulse,
  output logic              req_level,
  output logic              wake
);
  localparam int LW = $clog2(LEVELS);
  localparam logic [IDX_W-1:0] BASE = IDX_W'(EXT_BASE);

  logic [LEVELS-1:0] pend, ext_prev;
  logic [LW-1:0]     lvl;
  logic [IDX_W-1:0]  new_idx;
  logic              cls_ext, allow, change, withdraw;

  assign pend = ext_irq | (soft_int & ~LEVELS'(1)) | (LEVELS'(soft_int[0]) << TIMER_LEVEL);

  always_comb begin
    lvl = '0;
    for (int i = 1; i < LEVELS; i++)
      if (pend[i]) lvl = LW'(i);
  end

  assign cls_ext  = cur_idx[IDX_W-1:LW] == BASE[IDX_W-1:LW];
  assign allow    = (cur_idx == '0) || cls_ext;
  assign new_idx  = BASE | IDX_W'(lvl);
  assign change   = allow && (lvl != '0) && (new_idx != cur_idx);
  assign withdraw = (pend == '0) && cls_ext;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= '0;
      req_pulse <= 1'b0;
      req_level <= 1'b0;
      wake      <= 1'b0;
      ext_prev  <= '0;
    end else begin
      ext_prev  <= ext_irq;
      wake      <= halted && |(ext_irq & ~ext_prev);
      req_pulse <= change;
      if (change) begin
        idx_q     <= new_idx;
        req_level <= 1'b1;
      end else if (withdraw) begin
        idx_q     <= '0;
        req_level <= 1'b0;
      end else begin
        idx_q     <= cur_idx;
      end
    end
  end

  // R5
  blocked_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_idx != '0 && cur_idx[IDX_W-1:LW] != BASE[IDX_W-1:LW]) |=> (idx_q == $past(cur_idx) && !req_pulse));

  // R4
  pulse_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse |-> (idx_q[IDX_W-1:LW] == BASE[IDX_W-1:LW] && idx_q[LW-1:0] != '0));

  // R8
  pulse_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_pulse |-> req_level);

  // R7
  withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_level) |-> (idx_q == '0));

  // R9
  wake_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake) |-> $past(halted));
endmodule

// File: tb/tb_pil_resolver.sv
module tb_pil_resolver;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] ext_irq, soft_int;
  logic [8:0]  cur_idx, frc_val;
  logic        halted, frc;
  logic [8:0]  idx_q;
  logic        req_pulse, req_level, wake;

  int checks = 0, fails = 0, cyc = 0;
  logic        m_req;
  logic [15:0] m_prev;

  always #2 clk = ~clk;

  assign cur_idx = frc ? frc_val : idx_q;

  pil_resolver dut (.clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .soft_int(soft_int),
    .cur_idx(cur_idx), .halted(halted), .idx_q(idx_q), .req_pulse(req_pulse),
    .req_level(req_level), .wake(wake));

  function automatic logic [15:0] pend_of(logic [15:0] e, logic [15:0] s);
    logic [15:0] p = e | {s[15:1], 1'b0};
    p[14] = p[14] | s[0];
    return p;
  endfunction

  function automatic logic [3:0] top_lvl(logic [15:0] p);
    logic [3:0] l = 0;
    for (int i = 15; i >= 1; i--) if (p[i]) begin l = 4'(i); break; end
    return l;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic [15:0] e, logic [15:0] s, logic h, logic f, logic [8:0] fv, string req);
    logic [15:0] p;
    logic [3:0]  l;
    logic [8:0]  c, ei;
    logic        cls, pul, wk;
    @(negedge clk);
    ext_irq = e; soft_int = s; halted = h; frc = f; frc_val = fv;
    #0;
    c   = f ? fv : idx_q;
    p   = pend_of(e, s);
    l   = top_lvl(p);
    cls = c[8:4] == 5'd4;
    pul = 1'b0;
    ei  = c;
    if ((c == 0 || cls) && l != 0 && (9'h40 | 9'(l)) != c) begin
      ei = 9'h40 | 9'(l); pul = 1'b1; m_req = 1'b1;
    end else if (p == 0 && cls) begin
      ei = 0; m_req = 1'b0;
    end
    wk = h && |(e & ~m_prev);
    m_prev = e;
    @(posedge clk); #1;
    chk({req, " idx"}, 32'(idx_q), 32'(ei));
    chk({req, " pulse"}, 32'(req_pulse), 32'(pul));
    chk({req, " level"}, 32'(req_level), 32'(m_req));
    chk({req, " wake"}, 32'(wake), 32'(wk));
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; ext_irq = 0; soft_int = 0; halted = 0; frc = 1; frc_val = 0;
    m_req = 0; m_prev = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    chk("R1 idx", 32'(idx_q), 0);
    chk("R1 req", 32'({req_pulse, req_level, wake}), 0);
    @(negedge clk); rst_n = 1;
    step(0, 0, 0, 0, 0, "R1 idle");
    // R2 timer bit maps to level 14
    step(0, 16'h0001, 0, 0, 0, "R2 timer");
    step(0, 0, 0, 0, 0, "R7 withdraw");
    // R3 level 0 alone is ignored
    step(16'h0001, 0, 1, 0, 0, "R3 lvl0");
    step(16'h0000, 0, 0, 0, 0, "R3 idle");
    // R3 R4 highest wins
    step(16'h0122, 16'h0008, 0, 0, 0, "R4 lvl8");
    step(16'h8122, 0, 1, 0, 0, "R3 lvl15 R9 wake");
    // R6 same index: no new strobe
    step(16'h8000, 0, 1, 0, 0, "R6 same R9 lower");
    // R5 non-external trap blocks install
    step(16'h0400, 0, 0, 1, 9'h024, "R5 block");
    step(16'h0000, 0, 0, 1, 9'h024, "R5 block clear");
    step(16'h0000, 0, 0, 0, 0, "R7 idle");
    for (int i = 0; i < 400; i++) begin
      logic [15:0] e = ($urandom % 3 == 0) ? 16'h0 : 16'($urandom) & 16'($urandom) & 16'($urandom);
      logic [15:0] s = ($urandom % 2 == 0) ? 16'h0 : 16'($urandom) & 16'($urandom);
      logic        f = ($urandom % 8 == 0);
      logic [8:0]  fv = ($urandom % 2) ? 9'h0 : 9'(($urandom % 3 + 1) << 4) | 9'($urandom % 16);
      step(e, s, 1'($urandom), f, fv, "R2 R3 R5 R6 R8 R9 random");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule